// File: doc/BRIEF.md
# Ratcheting Boot-Layer Access Controller

This block is a hardware gate placed between a processor and two protected memories. The first is a battery-backed secret RAM divided into one page per code layer. The second is the Flash array that holds boot and application code. The gate keeps a small privilege level that starts at zero after a hardware reset. Software can only raise it by one step at a time, and only a reset can lower it again. The gate sits outside the processor, so the processor cannot bypass it. Even hostile code running on the processor therefore cannot reach pages that belong to the layers below it.

Each request names an operation and a target page. The operation is a page read, a page write, or a Flash write. The gate compares the request with the current level and passes it to the memory ports only when it is allowed. When the request is refused, a read returns zeros, a write never reaches the memory, and a fault flag pulses. The decision is registered, so the response appears one clock after the request. A single control write that carries exactly the next level moves the ratchet up. Any other control write is rejected and recorded in a sticky violation flag.

Top module: `layer_gate`

## Requirements
- R1: After reset the level is 0 and the violation flag is clear. No response is valid and no fault is raised, and at level 0 every page and Flash writes are open.
- R2: A control write whose value equals the current level plus one raises the level by exactly one at the next clock, provided the level is below the ceiling. The level never decreases except by reset.
- R3: A control write with any other value leaves the level unchanged and sets the violation flag. The flag then stays set until reset.
- R4: The level saturates at MAX_STATE (4 by default). At the ceiling every control write is ignored and sets the violation flag.
- R5: A page access is granted only when the page number is at least the current level and no larger than MAX_STATE. Page 1 holds the device key, so it becomes unreachable once the level reaches 2.
- R6: A Flash write is granted only while the level is at most FLASH_OPEN_MAX (1 by default).
- R7: The request opcode req_op is encoded as 0 for a page read, 1 for a page write, 2 for a Flash write, and 3 for a reserved operation. A reserved request is always denied.
- R8: Every valid request produces a response one clock later. The decision uses the level held before any control write in the same cycle.
- R9: A denied request returns zero read data and drives no RAM or Flash strobe. It pulses acc_fault for exactly that one response cycle.
- R10: A granted page read returns the RAM data for the requested page. A granted page write drives ram_en and ram_we together with the page and write data. A granted Flash write drives flash_we with the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | STATE_W | Requested next level |
| req_valid | input | 1 | Access request valid |
| req_op | input | 2 | Opcode: 0 page read, 1 page write, 2 Flash write, 3 reserved |
| req_page | input | PAGE_W | Target page number |
| req_wdata | input | DATA_W | Write data |
| ram_rdata | input | DATA_W | Read data returned by the secret RAM |
| ram_en | output | 1 | Secret RAM access enable |
| ram_we | output | 1 | Secret RAM write enable |
| ram_page | output | PAGE_W | Secret RAM page select |
| ram_wdata | output | DATA_W | Secret RAM write data |
| flash_we | output | 1 | Flash write strobe |
| flash_wdata | output | DATA_W | Flash write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_grant | output | 1 | Request was granted |
| rsp_rdata | output | DATA_W | Read data, zero unless a granted read |
| acc_fault | output | 1 | One-cycle pulse on a denied request |
| priv_state | output | STATE_W | Current privilege level |
| ctl_violation | output | 1 | Sticky illegal-control-write flag |

## Verification
The bench builds the gate with its default parameters: MAX_STATE of 4, a page field of 3 bits, and FLASH_OPEN_MAX of 1. These defaults leave three page codes (5 to 7) beyond the last real page, so the bench can check that out-of-range pages are refused. The 3-bit control field can also carry the value 5 at the ceiling, so the bench can check the saturation rule. The Flash lock crossing between levels 1 and 2 is reached as well. The stimulus walks the level from 0 to 4 and issues requests on both sides of the page floor. In some cycles a request coincides with an advance, which shows that the decision uses the level held before the advance.

// File: rtl/layer_gate_pkg.sv
package layer_gate_pkg;

   typedef enum logic [1:0] {
      OP_PAGE_RD  = 2'd0,
      OP_PAGE_WR  = 2'd1,
      OP_FLASH_WR = 2'd2,
      OP_RSVD     = 2'd3
   } gate_op_e;

   typedef struct packed {
      logic grant;
      logic page_rd;
      logic page_wr;
      logic flash_wr;
   } gate_dec_t;

endpackage

// File: rtl/lg_ratchet.sv
module lg_ratchet #(
   parameter int MAX_STATE = 4,
   parameter int STATE_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic [STATE_W-1:0] ctl_wdata,
   output logic [STATE_W-1:0] state_q,
   output logic               viol_q
);
   localparam logic [STATE_W-1:0] CEIL = STATE_W'(MAX_STATE);

   logic at_ceil;
   logic step_ok;

   assign at_ceil = (state_q == CEIL);
   assign step_ok = ctl_wr && !at_ceil && (ctl_wdata == state_q + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         viol_q  <= 1'b0;
      end else begin
         if (step_ok)
            state_q <= state_q + 1'b1;
         if (ctl_wr && !step_ok)
            viol_q <= 1'b1;
      end
   end
endmodule

// File: rtl/lg_policy.sv
module lg_policy
   import layer_gate_pkg::*;
#(
   parameter int MAX_STATE      = 4,
   parameter int STATE_W        = 3,
   parameter int PAGE_W         = 3,
   parameter int FLASH_OPEN_MAX = 1
) (
   input  logic [STATE_W-1:0] state,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [PAGE_W-1:0]  req_page,
   output gate_dec_t          dec
);
   localparam int NUM_PAGES = MAX_STATE + 1;
   localparam int SLOTS     = 1 << PAGE_W;

   logic [SLOTS-1:0] open_v;
   logic             page_ok;
   logic             flash_ok;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_PAGES) begin : g_real
         assign open_v[i] = (int'(state) <= i);
      end else begin : g_void
         assign open_v[i] = 1'b0;
      end
   end

   assign page_ok  = open_v[req_page];
   assign flash_ok = (int'(state) <= FLASH_OPEN_MAX);

   always_comb begin
      dec = '0;
      if (req_valid) begin
         case (req_op)
            OP_PAGE_RD: begin
               dec.page_rd = page_ok;
               dec.grant   = page_ok;
            end
            OP_PAGE_WR: begin
               dec.page_wr = page_ok;
               dec.grant   = page_ok;
            end
            OP_FLASH_WR: begin
               dec.flash_wr = flash_ok;
               dec.grant    = flash_ok;
            end
            default: dec = '0;
         endcase
      end
   end
endmodule

// File: rtl/lg_resp_reg.sv
module lg_resp_reg
   import layer_gate_pkg::*;
#(
   parameter int PAGE_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  gate_dec_t         dec,
   input  logic [PAGE_W-1:0] req_page,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [PAGE_W-1:0] ram_page,
   output logic [DATA_W-1:0] wdata,
   output logic              flash_we,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              acc_fault
);
   logic rd_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_en    <= 1'b0;
         ram_we    <= 1'b0;
         ram_page  <= '0;
         wdata     <= '0;
         flash_we  <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         acc_fault <= 1'b0;
         rd_ok_q   <= 1'b0;
      end else begin
         ram_en    <= dec.page_rd | dec.page_wr;
         ram_we    <= dec.page_wr;
         flash_we  <= dec.flash_wr;
         rsp_valid <= req_valid;
         rsp_grant <= dec.grant;
         acc_fault <= req_valid & ~dec.grant;
         rd_ok_q   <= dec.page_rd;
         if (dec.page_rd | dec.page_wr)
            ram_page <= req_page;
         if (dec.page_wr | dec.flash_wr)
            wdata <= req_wdata;
      end
   end

   assign rsp_rdata = rd_ok_q ? ram_rdata : '0;
endmodule

// File: rtl/layer_gate.sv
module layer_gate
   import layer_gate_pkg::*;
#(
   parameter int MAX_STATE      = 4,
   parameter int PAGE_W         = 3,
   parameter int DATA_W         = 32,
   parameter int FLASH_OPEN_MAX = 1,
   localparam int STATE_W       = $clog2(MAX_STATE + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic [STATE_W-1:0] ctl_wdata,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [PAGE_W-1:0]  req_page,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [DATA_W-1:0]  ram_rdata,
   output logic               ram_en,
   output logic               ram_we,
   output logic [PAGE_W-1:0]  ram_page,
   output logic [DATA_W-1:0]  ram_wdata,
   output logic               flash_we,
   output logic [DATA_W-1:0]  flash_wdata,
   output logic               rsp_valid,
   output logic               rsp_grant,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               acc_fault,
   output logic [STATE_W-1:0] priv_state,
   output logic               ctl_violation
);
   if (MAX_STATE < 2) begin : g_bad_max
      $error("layer_gate: MAX_STATE must be at least 2");
   end
   if ((1 << PAGE_W) < MAX_STATE + 1) begin : g_bad_page
      $error("layer_gate: PAGE_W too narrow for MAX_STATE+1 pages");
   end
   if (PAGE_W > 8) begin : g_bad_pw
      $error("layer_gate: PAGE_W above 8 is not supported");
   end
   if (FLASH_OPEN_MAX < 0 || FLASH_OPEN_MAX > MAX_STATE) begin : g_bad_fl
      $error("layer_gate: FLASH_OPEN_MAX out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("layer_gate: DATA_W must be positive");
   end

   gate_dec_t          dec;
   logic [DATA_W-1:0]  wdata_q;

   lg_ratchet #(
      .MAX_STATE (MAX_STATE),
      .STATE_W   (STATE_W)
   ) u_ratchet (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .state_q   (priv_state),
      .viol_q    (ctl_violation)
   );

   lg_policy #(
      .MAX_STATE      (MAX_STATE),
      .STATE_W        (STATE_W),
      .PAGE_W         (PAGE_W),
      .FLASH_OPEN_MAX (FLASH_OPEN_MAX)
   ) u_policy (
      .state     (priv_state),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_page  (req_page),
      .dec       (dec)
   );

   lg_resp_reg #(
      .PAGE_W (PAGE_W),
      .DATA_W (DATA_W)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .dec       (dec),
      .req_page  (req_page),
      .req_wdata (req_wdata),
      .ram_rdata (ram_rdata),
      .ram_en    (ram_en),
      .ram_we    (ram_we),
      .ram_page  (ram_page),
      .wdata     (wdata_q),
      .flash_we  (flash_we),
      .rsp_valid (rsp_valid),
      .rsp_grant (rsp_grant),
      .rsp_rdata (rsp_rdata),
      .acc_fault (acc_fault)
   );

   assign ram_wdata   = wdata_q;
   assign flash_wdata = wdata_q;
endmodule

// File: rtl/lg_checker.sv
module lg_checker #(
   parameter int MAX_STATE      = 4,
   parameter int STATE_W        = 3,
   parameter int PAGE_W         = 3,
   parameter int DATA_W         = 32,
   parameter int FLASH_OPEN_MAX = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [STATE_W-1:0] priv_state,
   input logic               ctl_violation,
   input logic               ram_en,
   input logic               ram_we,
   input logic [PAGE_W-1:0]  ram_page,
   input logic               flash_we,
   input logic               rsp_valid,
   input logic               rsp_grant,
   input logic [DATA_W-1:0]  rsp_rdata,
   input logic               acc_fault
);
   assert_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(priv_state) >= int'($past(priv_state))));

   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(priv_state) <= int'($past(priv_state)) + 1));

   assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(priv_state) <= MAX_STATE);

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_violation |=> ctl_violation);

   assert_page_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> (int'(ram_page) >= int'($past(priv_state)) && int'(ram_page) <= MAX_STATE));

   assert_flash_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flash_we |-> (int'($past(priv_state)) <= FLASH_OPEN_MAX));

   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault |-> (rsp_valid && !rsp_grant && !ram_en && !flash_we));

   assert_zero_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_grant |-> (rsp_rdata == '0));

   assert_we_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_en);
endmodule

bind layer_gate lg_checker #(
   .MAX_STATE      (MAX_STATE),
   .STATE_W        (STATE_W),
   .PAGE_W         (PAGE_W),
   .DATA_W         (DATA_W),
   .FLASH_OPEN_MAX (FLASH_OPEN_MAX)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .priv_state    (priv_state),
   .ctl_violation (ctl_violation),
   .ram_en        (ram_en),
   .ram_we        (ram_we),
   .ram_page      (ram_page),
   .flash_we      (flash_we),
   .rsp_valid     (rsp_valid),
   .rsp_grant     (rsp_grant),
   .rsp_rdata     (rsp_rdata),
   .acc_fault     (acc_fault)
);

// File: tb/layer_gate_test.sv
module layer_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int STATE_W    = 3;
   localparam int PAGE_W     = 3;
   localparam int DATA_W     = 32;
   localparam int NV         = 21;

   // {ctl_wr, ctl_val[3], op[2], page[3], exp_grant, exp_state[3], exp_viol}
   localparam logic [13:0] VEC [NV] = '{
      {1'b0, 3'd0, 2'd0, 3'd0, 1'b1, 3'd0, 1'b0},
      {1'b0, 3'd0, 2'd1, 3'd0, 1'b1, 3'd0, 1'b0},
      {1'b0, 3'd0, 2'd2, 3'd0, 1'b1, 3'd0, 1'b0},
      {1'b1, 3'd1, 2'd0, 3'd0, 1'b1, 3'd1, 1'b0},
      {1'b0, 3'd0, 2'd0, 3'd0, 1'b0, 3'd1, 1'b0},
      {1'b0, 3'd0, 2'd0, 3'd1, 1'b1, 3'd1, 1'b0},
      {1'b0, 3'd0, 2'd2, 3'd0, 1'b1, 3'd1, 1'b0},
      {1'b1, 3'd3, 2'd0, 3'd4, 1'b1, 3'd1, 1'b1},
      {1'b1, 3'd2, 2'd2, 3'd0, 1'b1, 3'd2, 1'b1},
      {1'b0, 3'd0, 2'd2, 3'd0, 1'b0, 3'd2, 1'b1},
      {1'b0, 3'd0, 2'd0, 3'd1, 1'b0, 3'd2, 1'b1},
      {1'b0, 3'd0, 2'd1, 3'd2, 1'b1, 3'd2, 1'b1},
      {1'b0, 3'd0, 2'd0, 3'd5, 1'b0, 3'd2, 1'b1},
      {1'b0, 3'd0, 2'd3, 3'd4, 1'b0, 3'd2, 1'b1},
      {1'b1, 3'd1, 2'd0, 3'd2, 1'b1, 3'd2, 1'b1},
      {1'b1, 3'd3, 2'd0, 3'd2, 1'b1, 3'd3, 1'b1},
      {1'b1, 3'd4, 2'd0, 3'd3, 1'b1, 3'd4, 1'b1},
      {1'b0, 3'd0, 2'd0, 3'd3, 1'b0, 3'd4, 1'b1},
      {1'b0, 3'd0, 2'd0, 3'd4, 1'b1, 3'd4, 1'b1},
      {1'b1, 3'd5, 2'd1, 3'd4, 1'b1, 3'd4, 1'b1},
      {1'b1, 3'd0, 2'd2, 3'd0, 1'b0, 3'd4, 1'b1}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               ctl_wr = 1'b0;
   logic [STATE_W-1:0] ctl_wdata = '0;
   logic               req_valid = 1'b0;
   logic [1:0]         req_op = '0;
   logic [PAGE_W-1:0]  req_page = '0;
   logic [DATA_W-1:0]  req_wdata = '0;
   logic [DATA_W-1:0]  ram_rdata;
   logic               ram_en, ram_we, flash_we;
   logic [PAGE_W-1:0]  ram_page;
   logic [DATA_W-1:0]  ram_wdata, flash_wdata, rsp_rdata;
   logic               rsp_valid, rsp_grant, acc_fault, ctl_violation;
   logic [STATE_W-1:0] priv_state;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign ram_rdata = ram_en ? (32'h5A5A_0000 | 32'(ram_page)) : 32'hDEAD_BEEF;

   layer_gate uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .req_valid(req_valid), .req_op(req_op), .req_page(req_page),
      .req_wdata(req_wdata), .ram_rdata(ram_rdata), .ram_en(ram_en),
      .ram_we(ram_we), .ram_page(ram_page), .ram_wdata(ram_wdata),
      .flash_we(flash_we), .flash_wdata(flash_wdata), .rsp_valid(rsp_valid),
      .rsp_grant(rsp_grant), .rsp_rdata(rsp_rdata), .acc_fault(acc_fault),
      .priv_state(priv_state), .ctl_violation(ctl_violation)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 level", 32'(priv_state), 0);
      chk("R1 violation", 32'(ctl_violation), 0);
      chk("R1 rsp_valid", 32'(rsp_valid), 0);
      chk("R1 fault", 32'(acc_fault), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 idle no response", 32'(rsp_valid), 0);

      for (int i = 0; i < NV; i++) begin
         logic [13:0] v;
         logic        g;
         logic [1:0]  op;
         logic [2:0]  pg;
         string       tg;
         v  = VEC[i];
         g  = v[4];
         op = v[9:8];
         pg = v[7:5];
         tg = (op == 2'd2) ? "R6" : (op == 2'd3) ? "R7" : "R5";
         ctl_wr    = v[13];
         ctl_wdata = v[12:10];
         req_valid = 1'b1;
         req_op    = op;
         req_page  = pg;
         req_wdata = 32'h0000_1000 + 32'(i);
         @(negedge clk);
         chk("R8 rsp_valid", 32'(rsp_valid), 1);
         chk({tg, " grant"}, 32'(rsp_grant), 32'(g));
         chk("R9 fault", 32'(acc_fault), 32'(!g));
         chk("R9 R10 rdata", rsp_rdata,
             (g && op == 2'd0) ? (32'h5A5A_0000 | 32'(pg)) : 32'h0);
         chk("R9 R10 ram_en", 32'(ram_en), 32'(g && op < 2'd2));
         chk("R9 R10 ram_we", 32'(ram_we), 32'(g && op == 2'd1));
         chk("R9 R10 flash_we", 32'(flash_we), 32'(g && op == 2'd2));
         if (g && op == 2'd1) begin
            chk("R10 ram_wdata", ram_wdata, 32'h0000_1000 + 32'(i));
            chk("R10 ram_page", 32'(ram_page), 32'(pg));
         end
         if (g && op == 2'd2)
            chk("R10 flash_wdata", flash_wdata, 32'h0000_1000 + 32'(i));
         chk("R2 R4 level", 32'(priv_state), 32'(v[3:1]));
         chk("R3 violation", 32'(ctl_violation), 32'(v[0]));
      end

      ctl_wr = 1'b0;
      req_valid = 1'b0;
      @(negedge clk);
      chk("R9 fault single cycle", 32'(acc_fault), 0);

      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 level after reset", 32'(priv_state), 0);
      chk("R1 violation after reset", 32'(ctl_violation), 0);
      rst_n = 1'b1;
      req_valid = 1'b1;
      req_op = 2'd0;
      req_page = 3'd0;
      @(negedge clk);
      chk("R1 page0 open after reset", 32'(rsp_grant), 1);
      chk("R1 page0 data", rsp_rdata, 32'h5A5A_0000);
      req_op = 2'd2;
      @(negedge clk);
      chk("R1 flash open after reset", 32'(flash_we), 1);
      req_valid = 1'b0;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule